// File: doc/BRIEF.md
# Register-Mapped SPI Master with Byte Queues

This block is an SPI master that a processor drives through a small word-wide register bus. Software pushes bytes into a transmit queue. Whenever transfers are not held off, the block takes each queued byte in turn and shifts it out on the serial clock and data-out lines. For every byte sent, it shifts one byte in from the serial data-in line and stores it in a receive queue.

A control register holds a hold-off bit and two self-clearing bits that empty either queue. A status register gives the empty and full flags of both queues, and two count registers give how many entries each queue holds. A slave-select register drives one active-low select line per attached slave. A keyed write to a reset register returns the whole block to its reset state.

The block raises single-cycle event pulses for a separate interrupt controller:

- receive overrun,
- receive queue filled,
- transmit queue drained,
- write to a full transmit queue.

Queue depth, serial clock divider and the number of select lines are parameters. The depth must be a power of two and the divider an even number of at least 2.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the status register (byte address 0x64) reads 0x5, both count registers (0x74 transmit, 0x78 receive) read 0, the control register (0x60) reads 0, and every select output is high.
- R2: A write to the transmit data register (0x68) queues only bits 7:0. Queued bytes go out in write order in SPI mode 0 (clock idle low, data-out stable at each rising edge), most significant bit first. The byte sampled from data-in at the eight rising edges is stored in the receive queue and read back in order from 0x6C in bits 7:0. When a byte finishes with the transmit queue empty, the transmit-drained pulse fires.
- R3: While control bit 8 (hold-off) is 1, queued bytes stay in the transmit queue and the serial clock stays low. Once the bit is 0, queued bytes are sent back to back until the queue is empty.
- R4: Writing control bit 5 as 1 empties the transmit queue, and writing control bit 6 as 1 empties the receive queue. Both bits always read back as 0, while bit 8 reads back as written.
- R5: Status bit 0 is receive-empty, bit 1 receive-full, bit 2 transmit-empty and bit 3 transmit-full, with all other bits 0. A write to the status register has no effect.
- R6: When a byte completes while the receive queue is already full, the byte is dropped and the overrun pulse fires. The push that fills the receive queue fires the receive-full pulse.
- R7: A read of 0x6C while the receive queue is empty returns 0xDEADBEEF and changes no state.
- R8: A write of exactly 0x0000000A to the reset register (0x40) restores the full reset state. A write of any other value there has no effect.
- R9: Select output i equals bit i of the slave-select register (0x70), so a 1 deselects (high) and a 0 selects (low).
- R10: Each count register reads the current entry count of its queue, and a write to it has no effect.
- R11: A transmit data write while the transmit queue holds DEPTH entries is dropped and fires the transmit-error pulse.
- R12: Successive rising edges of the serial clock inside a byte are CLK_DIV system clocks apart, and the serial clock is low whenever no byte is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 7 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SS_W | Active-low slave selects |
| ev_overrun | output | 1 | Pulse: received byte dropped, receive queue full |
| ev_rx_full | output | 1 | Pulse: receive queue became full |
| ev_tx_empty | output | 1 | Pulse: byte finished with transmit queue empty |
| ev_tx_error | output | 1 | Pulse: write to full transmit queue dropped |

## Verification
The embedded properties assume that a read and a write strobe never arrive in the same cycle. They also assume that bus_addr and bus_wdata are meaningful only while a strobe is high. The stimulus issues one access at a time, each held for exactly one clock, and holds the data-in line to the inverse of data-out so that every received byte is predictable. Queue flushes and the keyed reset are issued only while hold-off is set and no byte is in flight, so the serial monitor never sees a truncated byte.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH   = 256,
  parameter int CLK_DIV = 4,
  parameter int SS_W    = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [6:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [SS_W-1:0] ss_n,
  output logic            ev_overrun,
  output logic            ev_rx_full,
  output logic            ev_tx_empty,
  output logic            ev_tx_error
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = $clog2(HALF) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  localparam logic [4:0] W_RST = 5'd16;
  localparam logic [4:0] W_CTL = 5'd24;
  localparam logic [4:0] W_STA = 5'd25;
  localparam logic [4:0] W_TXD = 5'd26;
  localparam logic [4:0] W_RXD = 5'd27;
  localparam logic [4:0] W_SEL = 5'd28;
  localparam logic [4:0] W_TXO = 5'd29;
  localparam logic [4:0] W_RXO = 5'd30;

  logic [7:0]      tx_mem [DEPTH];
  logic [7:0]      rx_mem [DEPTH];
  logic [AW-1:0]   tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            hold;
  logic [SS_W-1:0] sel_reg;
  logic            busy;
  logic [2:0]      bitn;
  logic [DW-1:0]   div;
  logic [7:0]      txsh, rxsh;

  wire [4:0] word = bus_addr[6:2];

  wire soft_rst = bus_wr && word == W_RST && bus_wdata == 32'h0000_000A;
  wire wr_ctl   = bus_wr && word == W_CTL;
  wire wr_tx    = bus_wr && word == W_TXD;
  wire wr_sel   = bus_wr && word == W_SEL;
  wire rd_rx    = bus_rd && word == W_RXD;

  wire tx_full  = tx_cnt == FULL_CNT;
  wire rx_full  = rx_cnt == FULL_CNT;
  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;

  wire flush_tx  = wr_ctl && bus_wdata[5];
  wire flush_rx  = wr_ctl && bus_wdata[6];
  wire tx_push   = wr_tx && !tx_full;
  wire start     = !busy && !hold && !tx_empty;
  wire tick      = busy && div == DW'(HALF - 1);
  wire byte_done = tick && sclk && bitn == 3'd7;
  wire rx_push   = byte_done && !rx_full;
  wire rx_pop    = rd_rx && !rx_empty;

  assign ev_overrun  = byte_done && rx_full;
  assign ev_rx_full  = rx_push && !rx_pop && rx_cnt == CW'(DEPTH - 1);
  assign ev_tx_empty = byte_done && tx_empty;
  assign ev_tx_error = wr_tx && tx_full;

  assign mosi = busy && txsh[7];
  assign ss_n = sel_reg;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rxsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      hold <= 1'b0; sel_reg <= '1;
    end else if (soft_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      hold <= 1'b0; sel_reg <= '1;
    end else begin
      if (wr_ctl) hold <= bus_wdata[8];
      if (wr_sel) sel_reg <= bus_wdata[SS_W-1:0];
      if (flush_tx) begin
        tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (start)   tx_rp <= tx_rp + 1'b1;
        tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
      end
      if (flush_rx) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk <= 1'b0; bitn <= '0; div <= '0;
      txsh <= '0; rxsh <= '0;
    end else if (soft_rst) begin
      busy <= 1'b0; sclk <= 1'b0; bitn <= '0; div <= '0;
      txsh <= '0; rxsh <= '0;
    end else if (start) begin
      busy <= 1'b1; sclk <= 1'b0; bitn <= '0; div <= '0;
      txsh <= tx_mem[tx_rp];
    end else if (busy) begin
      if (tick) begin
        div  <= '0;
        sclk <= !sclk;
        if (!sclk) rxsh <= {rxsh[6:0], miso};
        else if (bitn == 3'd7) busy <= 1'b0;
        else begin
          bitn <= bitn + 3'd1;
          txsh <= {txsh[6:0], 1'b0};
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (word)
      W_CTL:   bus_rdata = {23'd0, hold, 8'd0};
      W_STA:   bus_rdata = {28'd0, tx_full, tx_empty, rx_full, rx_empty};
      W_RXD:   bus_rdata = rx_empty ? 32'hDEAD_BEEF : {24'd0, rx_mem[rx_rp]};
      W_SEL:   bus_rdata = 32'(sel_reg);
      W_TXO:   bus_rdata = 32'(tx_cnt);
      W_RXO:   bus_rdata = 32'(rx_cnt);
      default: bus_rdata = '0;
    endcase
  end

  a_r12_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r3_hold_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !busy && !soft_rst) |=> !busy);

  a_r11_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL_CNT);

  a_r6_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL_CNT);

  a_r6_overrun_full: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> rx_full);

  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && rx_empty && !byte_done) |=> (rx_empty && $stable(rx_rp)));

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_empty && rx_empty && !busy && ss_n == '1));
endmodule

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;
  localparam int DEPTH = 256;
  localparam int CDIV  = 4;
  localparam int SSW   = 3;

  logic        clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sclk, mosi, miso;
  logic [SSW-1:0] ss_n;
  logic        ev_overrun, ev_rx_full, ev_tx_empty, ev_tx_error;

  int checks = 0, errors = 0, cyc = 0;
  int n_ovr = 0, n_rxf = 0, n_txe = 0, n_err = 0;
  logic [7:0] exp_q[$];
  logic [31:0] d;

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spi_fifo_master #(.DEPTH(DEPTH), .CLK_DIV(CDIV), .SS_W(SSW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
    .ev_overrun(ev_overrun), .ev_rx_full(ev_rx_full),
    .ev_tx_empty(ev_tx_empty), .ev_tx_error(ev_tx_error));

  always @(posedge clk) begin
    cyc++;
    if (ev_overrun)  n_ovr++;
    if (ev_rx_full)  n_rxf++;
    if (ev_tx_empty) n_txe++;
    if (ev_tx_error) n_err++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic [23:0] junk, input bit accepted);
    wr(7'h68, {junk, b});
    if (accepted) exp_q.push_back(b);
  endtask

  task automatic drain();
    logic [31:0] v;
    do rd(7'h74, v); while (v != 0);
    repeat (8 * CDIV + 8) @(negedge clk);
  endtask

  initial begin : monitor
    logic [7:0] bits = '0;
    int n = 0, last = 0;
    forever begin
      @(posedge sclk);
      bits = {bits[6:0], mosi};
      n++;
      if (n > 1) chk("R12 rising-edge spacing", cyc - last, CDIV);
      last = cyc;
      if (n == 8) begin
        n = 0;
        if (exp_q.size() == 0) chk("R2 unexpected byte on mosi", {24'd0, bits}, 32'hFFFF_FFFF);
        else chk("R2 mosi byte msb first", {24'd0, bits}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(7'h64, d); chk("R1 status after reset", d, 32'h5);
    rd(7'h74, d); chk("R1 tx count after reset", d, 0);
    rd(7'h78, d); chk("R1 rx count after reset", d, 0);
    rd(7'h60, d); chk("R1 control after reset", d, 0);
    chk("R1 selects high", {29'd0, ss_n}, 32'h7);
    chk("R12 sclk idle low", {31'd0, sclk}, 0);

    rd(7'h6C, d); chk("R7 empty read sentinel", d, 32'hDEADBEEF);
    rd(7'h78, d); chk("R7 rx count unchanged", d, 0);
    rd(7'h64, d); chk("R7 status unchanged", d, 32'h5);

    t0 = n_txe;
    send(8'hA5, 24'h000001, 1);
    send(8'h3C, 24'hFFFFFF, 1);
    drain();
    rd(7'h78, d); chk("R2 two bytes received", d, 2);
    rd(7'h6C, d); chk("R2 first rx byte", d, 32'h5A);
    rd(7'h6C, d); chk("R2 second rx byte", d, 32'hC3);
    chk("R2 tx drained pulse", n_txe - t0, 1);

    wr(7'h60, 32'h100);
    send(8'h81, 24'h0, 1); send(8'h42, 24'h0, 1); send(8'h00, 24'h0, 1);
    repeat (100) @(negedge clk);
    rd(7'h74, d); chk("R3 bytes held while inhibited", d, 3);
    rd(7'h78, d); chk("R3 nothing received while inhibited", d, 0);
    chk("R3 sclk low while inhibited", {31'd0, sclk}, 0);
    wr(7'h60, 32'h0);
    drain();
    rd(7'h78, d); chk("R3 drained after release", d, 3);
    rd(7'h64, d); chk("R5 status tx empty rx nonempty", d, 32'h4);
    wr(7'h64, 32'hF);
    rd(7'h64, d); chk("R5 status write ignored", d, 32'h4);
    rd(7'h6C, d); chk("R3 rx byte 1", d, 32'h7E);
    rd(7'h6C, d); chk("R3 rx byte 2", d, 32'hBD);
    rd(7'h6C, d); chk("R3 rx byte 3", d, 32'hFF);

    wr(7'h60, 32'h100);
    for (int i = 0; i < DEPTH; i++) send(i[7:0], 24'h0, 1);
    rd(7'h64, d); chk("R5 status tx full rx empty", d, 32'h9);
    t0 = n_err;
    send(8'h77, 24'h0, 0);
    chk("R11 error pulse on full write", n_err - t0, 1);
    rd(7'h74, d); chk("R11 tx count stays full", d, DEPTH);
    wr(7'h60, 32'h120);
    exp_q.delete();
    rd(7'h74, d); chk("R4 tx flushed", d, 0);
    rd(7'h60, d); chk("R4 control readback", d, 32'h100);

    wr(7'h74, 32'h55);
    rd(7'h74, d); chk("R10 count write ignored", d, 0);

    wr(7'h60, 32'h0);
    t0 = n_ovr;
    for (int i = 0; i <= DEPTH; i++) send(i[7:0], 24'h0, 1);
    drain();
    rd(7'h78, d); chk("R10 rx count full", d, DEPTH);
    rd(7'h64, d); chk("R6 status rx full", d, 32'h6);
    chk("R6 overrun pulse", n_ovr - t0, 1);
    chk("R6 rx full pulse", n_rxf, 1);
    rd(7'h6C, d); chk("R6 oldest byte kept", d, 32'hFF);
    rd(7'h6C, d); chk("R6 next byte", d, 32'hFE);
    wr(7'h60, 32'h40);
    rd(7'h78, d); chk("R4 rx flushed", d, 0);
    rd(7'h64, d); chk("R4 status after rx flush", d, 32'h5);

    wr(7'h70, 32'h5);
    chk("R9 select pattern 101", {29'd0, ss_n}, 32'h5);
    wr(7'h70, 32'h2);
    chk("R9 select pattern 010", {29'd0, ss_n}, 32'h2);

    wr(7'h60, 32'h100);
    send(8'h11, 24'h0, 1);
    wr(7'h40, 32'h5);
    chk("R8 wrong key keeps selects", {29'd0, ss_n}, 32'h2);
    rd(7'h74, d); chk("R8 wrong key keeps queue", d, 1);
    rd(7'h60, d); chk("R8 wrong key keeps control", d, 32'h100);
    wr(7'h40, 32'hA);
    exp_q.delete();
    chk("R8 key restores selects", {29'd0, ss_n}, 32'h7);
    rd(7'h74, d); chk("R8 key clears queue", d, 0);
    rd(7'h60, d); chk("R8 key clears control", d, 0);
    repeat (50) @(negedge clk);
    chk("R8 no byte after reset", {31'd0, sclk}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule